// File: doc/BRIEF.md
# Banked GPIO Controller with Edge and Level Interrupts

This block is a word-addressed general-purpose I/O controller for three banks of 32 pins. Each bank has its own direction mask and output value. It reads back the synchronised level of every pin. Each pin has enables for rising-edge, falling-edge, high-level and low-level interrupts. The output value never takes a written word directly. Software raises bits through a set register and drops them through a clear register, so no read-modify-write is needed on the output state.

Every input passes through a two-stage synchroniser. A per-bank polarity mask can invert the level that the interrupt logic sees. Qualified events are held in a sticky status word. Each status bit is cleared by writing one to it. A second sticky word records edge events only. One interrupt line covers all banks and stays high while any status bit is set.

The register bus is a simple 32-bit word bus. A request is held for one cycle and answered one cycle later with a ready pulse. Read data is valid in the cycle of that pulse.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset every register is zero. This gives all pins as inputs (`pin_oe` = 0), `pin_out` = 0, every interrupt source disabled and `irq` = 0.
- R2: A register sits at byte address fn*0x10 + bank*4 on an 8-bit address. The function codes are: 0 direction, 1 polarity, 2 pin level, 3 output-set, 4 output-clear, 5 rising enable, 6 falling enable, 7 high-level enable, 8 low-level enable, 9 status, 10 edge status. An address is unmapped when the function code is above 10, the bank is 3 or higher, or address bits [1:0] are not zero. An unmapped address reads as zero and ignores writes.
- R3: Direction bit n = 1 drives `pin_oe` for that pin high (output); 0 makes it an input. The register reads back as written.
- R4: A write to output-set ORs the word into the bank's output value. A write to output-clear removes the word's one bits from it. Zero bits change nothing. The result appears on `pin_out` after the write cycle. Both strobe registers read as zero.
- R5: Reading the pin-level register returns the bank's `pin_in` levels after two synchroniser stages. The polarity mask does not change this value.
- R6: With the rising enable set, a 0-to-1 change of the detected level sets the status bit. With the falling enable set, a 1-to-0 change sets it. With both set, either change sets it. A change in a direction whose enable is clear sets nothing.
- R7: While a high-level (low-level) enable bit is set and the detected level is 1 (0), the status bit is set again every cycle, so a clear cannot remove it.
- R8: Polarity bit n = 1 inverts pin n's level before edge and level detection. A falling pin then counts as a rising edge. Polarity resets to 0.
- R9: Writing the status register clears the bits written as one and keeps the bits written as zero. If an event for a bit arrives in the same cycle as its clear, the bit stays set.
- R10: The edge status register latches edge events only, never level events. It is cleared by writing one, the same way as the status register.
- R11: `irq` is high exactly while any status bit in any bank is set.
- R12: `bus_ready` goes high for one cycle in the cycle after each request with `bus_en` high. For reads, `bus_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Request valid, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completed |
| pin_in | input | 96 | Pin levels from the pads, bank 0 in bits 31:0 |
| pin_out | output | 96 | Output values |
| pin_oe | output | 96 | Output enables (1 = drive) |
| irq | output | 1 | Combined interrupt |

## Verification
The hazard is a clear write to the status register that lands in the same cycle as a fresh event on the same bit. The bench makes this happen by changing a pin and then waiting the exact synchroniser and comparison delay before it issues the clear. The status bit must then read back as one. A second case sets a level enable and clears while the level is still present; the bit must survive. In both cases any surviving bit must keep `irq` high.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    typedef enum logic [3:0] {
        FN_DIR  = 4'd0,
        FN_POL  = 4'd1,
        FN_LVL  = 4'd2,
        FN_SET  = 4'd3,
        FN_CLR  = 4'd4,
        FN_REN  = 4'd5,
        FN_FEN  = 4'd6,
        FN_HEN  = 4'd7,
        FN_LEN  = 4'd8,
        FN_STAT = 4'd9,
        FN_EDGE = 4'd10
    } gpio_fn_e;

    localparam int FN_W = 4;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_ctrl_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [FN_W-1:0] wr_fn,
    input  logic [W-1:0]    wdata,
    input  logic [FN_W-1:0] rd_fn,
    output logic [W-1:0]    rdata,
    input  logic [W-1:0]    pin_in,
    output logic [W-1:0]    pin_out,
    output logic [W-1:0]    pin_oe,
    output logic            irq_any
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] pol;
        logic [W-1:0] outv;
        logic [W-1:0] ren;
        logic [W-1:0] fen;
        logic [W-1:0] hen;
        logic [W-1:0] len;
        logic [W-1:0] ist;
        logic [W-1:0] est;
        logic [W-1:0] prev;
    } bank_regs_t;

    bank_regs_t   st_q, st_d;
    logic [W-1:0] sync_lvl;
    logic [W-1:0] det_lvl, ev_rise, ev_fall, ev_level, st_clr, ed_clr;

    gpio_sync #(.W(W), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (sync_lvl)
    );

    always_comb begin
        st_d     = st_q;
        det_lvl  = sync_lvl ^ st_q.pol;
        ev_rise  = det_lvl & ~st_q.prev & st_q.ren;
        ev_fall  = ~det_lvl & st_q.prev & st_q.fen;
        ev_level = (det_lvl & st_q.hen) | (~det_lvl & st_q.len);
        st_clr   = (wr_en && wr_fn == FN_STAT) ? wdata : '0;
        ed_clr   = (wr_en && wr_fn == FN_EDGE) ? wdata : '0;
        if (wr_en) begin
            case (gpio_fn_e'(wr_fn))
                FN_DIR:  st_d.dir  = wdata;
                FN_POL:  st_d.pol  = wdata;
                FN_SET:  st_d.outv = st_q.outv | wdata;
                FN_CLR:  st_d.outv = st_q.outv & ~wdata;
                FN_REN:  st_d.ren  = wdata;
                FN_FEN:  st_d.fen  = wdata;
                FN_HEN:  st_d.hen  = wdata;
                FN_LEN:  st_d.len  = wdata;
                default: ;
            endcase
        end
        st_d.ist  = (st_q.ist & ~st_clr) | ev_rise | ev_fall | ev_level;
        st_d.est  = (st_q.est & ~ed_clr) | ev_rise | ev_fall;
        st_d.prev = det_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (gpio_fn_e'(rd_fn))
            FN_DIR:  rdata = st_q.dir;
            FN_POL:  rdata = st_q.pol;
            FN_LVL:  rdata = sync_lvl;
            FN_REN:  rdata = st_q.ren;
            FN_FEN:  rdata = st_q.fen;
            FN_HEN:  rdata = st_q.hen;
            FN_LEN:  rdata = st_q.len;
            FN_STAT: rdata = st_q.ist;
            FN_EDGE: rdata = st_q.est;
            default: rdata = '0;
        endcase
    end

    assign pin_out = st_q.outv;
    assign pin_oe  = st_q.dir;
    assign irq_any = |st_q.ist;

    p_oe_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> $past(wr_en && wr_fn == FN_DIR));

    p_out_needs_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_out) |-> $past(wr_en && (wr_fn == FN_SET || wr_fn == FN_CLR)));

    p_status_drop_needs_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(st_q.ist) & ~st_q.ist)) |-> $past(wr_en && wr_fn == FN_STAT));

    p_edge_also_in_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.est & ~$past(st_q.est) & ~st_q.ist) == '0));
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_en,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    output logic                        bus_ready,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
    output logic [NUM_BANKS*BANK_W-1:0] pin_out,
    output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    output logic                        irq
);
    localparam int BK_W    = 2;
    localparam int BK_LSB  = 2;
    localparam int FN_LSB  = BK_LSB + BK_W;

    typedef struct packed {
        logic              ready;
        logic [BANK_W-1:0] rdata;
    } bus_regs_t;

    bus_regs_t         bus_q, bus_d;
    logic [FN_W-1:0]   acc_fn;
    logic [BK_W-1:0]   acc_bk;
    logic              acc_hit;
    logic [BANK_W-1:0] bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;
    logic [BANK_W-1:0] rd_sel;

    assign acc_fn  = bus_addr[FN_LSB +: FN_W];
    assign acc_bk  = bus_addr[BK_LSB +: BK_W];
    assign acc_hit = (acc_fn <= FN_EDGE) && (32'(acc_bk) < NUM_BANKS)
                     && (bus_addr[BK_LSB-1:0] == '0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(.W(BANK_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_en && bus_we && acc_hit && (acc_bk == BK_W'(b))),
            .wr_fn  (acc_fn),
            .wdata  (bus_wdata),
            .rd_fn  (acc_fn),
            .rdata  (bank_rd[b]),
            .pin_in (pin_in[b*BANK_W +: BANK_W]),
            .pin_out(pin_out[b*BANK_W +: BANK_W]),
            .pin_oe (pin_oe[b*BANK_W +: BANK_W]),
            .irq_any(bank_irq[b])
        );
    end

    always_comb begin
        rd_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (acc_bk == BK_W'(b)) rd_sel = bank_rd[b];
        end
        bus_d.ready = bus_en;
        bus_d.rdata = (bus_en && !bus_we && acc_hit) ? rd_sel : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign bus_ready = bus_q.ready;
    assign bus_rdata = bus_q.rdata;
    assign irq       = |bank_irq;

    p_ready_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |=> bus_ready);

    p_ready_has_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> $past(bus_en));

    p_unmapped_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && !acc_hit) |=> (bus_rdata == '0));

    p_irq_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_en && bus_we && acc_fn == FN_STAT)) |=> irq);
endmodule

// File: tb/sim_gpio_banked_ctrl.sv
module sim_gpio_banked_ctrl;
    localparam int NB = 3;
    localparam int BW = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_en = 1'b0;
    logic           bus_we = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [BW-1:0]  bus_wdata = '0;
    logic [BW-1:0]  bus_rdata;
    logic           bus_ready;
    logic [NB*BW-1:0] pins = '0;
    logic [NB*BW-1:0] pin_out, pin_oe;
    logic           irq;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    gpio_banked_ctrl #(.NUM_BANKS(NB), .BANK_W(BW), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pin_in(pins), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        check(bus_ready == 1'b1, "R12 ready", bus_ready, 1);
        d = bus_rdata;
    endtask

    task automatic expect_read(input logic [7:0] a, input logic [31:0] e, input string req);
        logic [31:0] v;
        bus_read(a, v);
        check(v == e, req, v, e);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check(pin_oe == '0, "R1 pin_oe", pin_oe, 0);
        check(pin_out == '0, "R1 pin_out", pin_out, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(bus_ready == 1'b0, "R1 ready idle", bus_ready, 0);
        expect_read(8'h00, 32'h0, "R1 dir bank0");
        expect_read(8'h18, 32'h0, "R8 polarity reset bank2");
        @(negedge clk);
        check(bus_ready == 1'b0, "R12 single ready pulse", bus_ready, 0);
    endtask

    task automatic t_direction();
        bus_write(8'h04, 32'hA5A5_0001);
        check(pin_oe == {32'h0, 32'hA5A5_0001, 32'h0}, "R3 pin_oe", pin_oe,
              {32'h0, 32'hA5A5_0001, 32'h0});
        expect_read(8'h04, 32'hA5A5_0001, "R3 readback");
    endtask

    task automatic t_set_clear();
        bus_write(8'h30, 32'h0000_00F0);
        check(pin_out[31:0] == 32'hF0, "R4 set", pin_out[31:0], 32'hF0);
        bus_write(8'h30, 32'h0000_000F);
        check(pin_out[31:0] == 32'hFF, "R4 set keeps", pin_out[31:0], 32'hFF);
        bus_write(8'h40, 32'h0000_003C);
        check(pin_out[31:0] == 32'hC3, "R4 clear", pin_out[31:0], 32'hC3);
        expect_read(8'h30, 32'h0, "R4 set reads zero");
    endtask

    task automatic t_data();
        pins[95:64] = 32'h1234_5678;
        settle();
        expect_read(8'h28, 32'h1234_5678, "R5 level read");
        pins[95:64] = 32'h0;
        settle();
        expect_read(8'h28, 32'h0, "R5 level read zero");
    endtask

    task automatic t_edges();
        bus_write(8'h50, 32'h1);
        pins[0] = 1'b1; settle();
        expect_read(8'h90, 32'h1, "R6 rising sets status");
        check(irq == 1'b1, "R11 irq on status", irq, 1);
        expect_read(8'hA0, 32'h1, "R10 edge status");
        bus_write(8'h90, 32'h0);
        expect_read(8'h90, 32'h1, "R9 zero write keeps");
        bus_write(8'h90, 32'h1);
        expect_read(8'h90, 32'h0, "R9 clear");
        check(irq == 1'b0, "R11 irq drops", irq, 0);
        pins[0] = 1'b0; settle();
        expect_read(8'h90, 32'h0, "R6 falling not enabled");
        bus_write(8'h60, 32'h1);
        pins[0] = 1'b1; settle();
        bus_write(8'h90, 32'h1);
        pins[0] = 1'b0; settle();
        expect_read(8'h90, 32'h1, "R6 both enables falling");
        bus_write(8'h90, 32'h1);
        bus_write(8'hA0, 32'h1);
        expect_read(8'hA0, 32'h0, "R10 edge clear");
    endtask

    task automatic t_coincide();
        pins[0] = 1'b1; settle();
        expect_read(8'h90, 32'h1, "R9 setup");
        pins[0] = 1'b0;
        @(negedge clk); @(negedge clk);
        bus_write(8'h90, 32'h1);
        expect_read(8'h90, 32'h1, "R9 event beats clear");
        check(irq == 1'b1, "R11 irq kept", irq, 1);
        bus_write(8'h90, 32'h1);
        expect_read(8'h90, 32'h0, "R9 later clear");
        bus_write(8'h50, 32'h0);
        bus_write(8'h60, 32'h0);
    endtask

    task automatic t_level();
        bus_write(8'h74, 32'h20);
        pins[37] = 1'b1; settle();
        expect_read(8'h94, 32'h20, "R7 high level");
        bus_write(8'h94, 32'h20);
        expect_read(8'h94, 32'h20, "R7 level survives clear");
        expect_read(8'hA4, 32'h0, "R10 no level in edge status");
        bus_write(8'h74, 32'h0);
        bus_write(8'h94, 32'h20);
        expect_read(8'h94, 32'h0, "R7 clear after disable");
        pins[37] = 1'b0;
        bus_write(8'h84, 32'h40); settle();
        expect_read(8'h94, 32'h40, "R7 low level");
        bus_write(8'h84, 32'h0);
        bus_write(8'h94, 32'h40);
        expect_read(8'h94, 32'h0, "R7 low clear");
    endtask

    task automatic t_polarity();
        pins[67] = 1'b1; settle();
        bus_write(8'h18, 32'h8); settle();
        bus_write(8'h58, 32'h8);
        pins[67] = 1'b0; settle();
        expect_read(8'h98, 32'h8, "R8 inverted falling counts as rising");
        expect_read(8'h28, 32'h0, "R8 level read not inverted");
        bus_write(8'h58, 32'h0);
        bus_write(8'h50, 32'h1);
        pins[0] = 1'b1; settle();
        bus_write(8'h98, 32'h8);
        check(irq == 1'b1, "R11 other bank holds irq", irq, 1);
        bus_write(8'h90, 32'h1);
        check(irq == 1'b0, "R11 all clear", irq, 0);
    endtask

    task automatic t_unmapped();
        bus_write(8'hB0, 32'hFFFF_FFFF);
        expect_read(8'hB0, 32'h0, "R2 fn 11 reads zero");
        bus_write(8'h0C, 32'hFFFF_FFFF);
        check(pin_oe == {32'h0, 32'hA5A5_0001, 32'h0}, "R2 bank3 write ignored", pin_oe,
              {32'h0, 32'hA5A5_0001, 32'h0});
        expect_read(8'h0C, 32'h0, "R2 bank3 reads zero");
        bus_write(8'h05, 32'hFFFF_FFFF);
        expect_read(8'h04, 32'hA5A5_0001, "R2 misaligned write ignored");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_set_clear();
        t_data();
        t_edges();
        t_coincide();
        t_level();
        t_polarity();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule